// File: doc/BRIEF.md
# Ethernet Transmit Pad and FCS Inserter

This block sits in the transmit path of an Ethernet MAC, between the frame source and the line encoder. Frames arrive one byte per beat on a valid/ready stream whose first and last bytes are marked. Depending on the configuration, the block passes each frame through unchanged, appends a 32-bit frame check sequence (FCS), or first fills a short frame with zero bytes up to the minimum size and then appends the FCS. A per-frame request to pad can raise the mode for a single frame.

When oversized frames are not allowed, a frame is cut at a programmable maximum length. The last byte that is sent carries an error mark, and the rest of that frame's input is consumed and discarded. Data bytes pass through with no added latency. Pad and FCS bytes follow the last data byte one per accepted beat. The input is held off while they are sent.

Top module: `eth_tx_fcs_pad`

## Requirements
- R1: With `cfg_pad_crc_en`, `cfg_crc_en` and `pkt_pad_crc_en` all low, a frame leaves with its bytes, start mark and end mark unchanged, and `out_err` stays low.
- R2: With only `cfg_crc_en` set, four FCS bytes are appended after the last data byte and no padding is added. The end mark moves to the last FCS byte.
- R3: With a pad request active, a frame with fewer than 60 data bytes gets zero bytes appended until it holds 60 bytes, and then the FCS, for 64 bytes in total. A frame of 60 or more data bytes gets only the FCS.
- R4: While either pad request (`cfg_pad_crc_en` or `pkt_pad_crc_en`) is active, `cfg_crc_en` has no effect. The output is identical to the output with the pad request alone.
- R5: `pkt_pad_crc_en` is sampled only on the start-marked byte and holds for that frame alone. A later change within the frame, and the setting for any following frame, do not alter the result.
- R6: The FCS is the CRC-32 with polynomial 0x04C11DB7, seed 0xFFFFFFFF, reflected input and inverted result. It covers the data and pad bytes. Bits 7:0 of the inverted result are sent first, then 15:8, 23:16 and 31:24.
- R7: With `cfg_huge_en` low, a frame longer than `cfg_max_len` bytes is cut after `cfg_max_len` bytes. That last byte carries `out_eof`=1 and `out_err`=1, and no FCS follows. The remaining input bytes are accepted (`in_ready`=1) and discarded. A frame of exactly `cfg_max_len` bytes is not cut.
- R8: With `cfg_huge_en` high, frames longer than `cfg_max_len` pass whole, with an FCS when one is enabled.
- R9: While `out_ready` is low, a presented output byte is held valid and unchanged. `in_ready` follows `out_ready` while data bytes pass, and is low while pad or FCS bytes are sent.
- R10: After reset, `out_valid` is low and the latched frame mode is cleared. A frame cut off by reset leaves no trace on the next frame.
- R11: A byte arriving between frames without a start mark is accepted and discarded. No output is produced for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pad_crc_en | input | 1 | Global pad-and-FCS request |
| cfg_crc_en | input | 1 | Global FCS-only request |
| cfg_huge_en | input | 1 | Allow frames above the maximum length |
| cfg_max_len | input | 16 | Maximum frame length in bytes (at least 1) |
| pkt_pad_crc_en | input | 1 | Per-frame pad-and-FCS request, sampled with the start byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last of a frame |
| out_err | output | 1 | Frame was cut at the maximum length |

## Verification
A data byte appears on the output in the same cycle it is offered. The first pad or FCS byte is presented in the cycle after the end-marked byte is accepted. Each further pad or FCS byte follows one cycle after the previous one is accepted. The bench therefore drives each beat after the falling edge, lets the combinational path settle for 1 ns, and records a beat only when `out_valid` and `out_ready` are both high at that point. Every recorded stream is compared byte by byte with a frame built from the requirements, including a CRC computed in a different, non-reflected form. Hold checks compare each stalled output byte with the byte seen one cycle earlier.

// File: rtl/eth_txfcs_pkg.sv
// Shared types and the CRC step function for the transmit pad/FCS inserter.
// Assumes the reflected (LSB-first) form of the Ethernet CRC-32.
package eth_txfcs_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BODY,
        ST_PAD,
        ST_FCS,
        ST_DROP
    } txf_state_e;

    // Advance a reflected CRC-32 remainder by one byte, LSB first.
    function automatic logic [31:0] crc32_byte(input logic [31:0] c_in, input logic [7:0] d);
        logic [31:0] c;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_REFL;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/tx_crc32.sv
// CRC-32 accumulator. On a step it folds one byte into the remainder.
// When start is high, it folds from the all-ones seed instead of the
// stored value. Assumes the caller steps only on bytes that are transferred.
module tx_crc32
    import eth_txfcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        step,
    input  logic [7:0]  data,
    output logic [31:0] crc_q
);

    logic [31:0] crc_base;

    // Pick the seed for the first byte of a frame, else the running remainder
    always_comb crc_base = start ? 32'hFFFF_FFFF : crc_q;

    // Update the remainder on every transferred data or pad byte
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= 32'hFFFF_FFFF;
        else if (step) crc_q <= crc32_byte(crc_base, data);
    end

    AST_CRC_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(crc_q)); // R6

endmodule

// File: rtl/tx_frame_ctl.sv
// Frame sequencer for the transmit pad/FCS inserter.
// It passes data bytes straight through, then adds zero pad bytes and FCS
// bytes as the latched mode asks. With oversize frames disallowed, it cuts
// a frame at the maximum length. Assumes cfg_huge_en and cfg_max_len are
// stable within a frame and cfg_max_len >= 1. The mode is latched on the
// start byte.
module tx_frame_ctl
    import eth_txfcs_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int MIN_DATA = 60,
    parameter int FCS_LEN  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_pad_crc_en,
    input  logic             cfg_crc_en,
    input  logic             cfg_huge_en,
    input  logic [LEN_W-1:0] cfg_max_len,
    input  logic             pkt_pad_crc_en,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic             out_err,
    output logic             crc_start,
    output logic             crc_step,
    input  logic [31:0]      crc_q
);

    localparam int                 IDX_W   = $clog2(FCS_LEN);
    localparam logic [LEN_W-1:0]   MIN_LEN = LEN_W'(MIN_DATA);
    localparam logic [IDX_W-1:0]   IDX_END = IDX_W'(FCS_LEN - 1);

    txf_state_e       state_q, state_d;
    logic [LEN_W-1:0] cnt_q, byte_num;
    logic [IDX_W-1:0] idx_q;
    logic             mode_pad_q, mode_crc_q;
    logic             live_pad, live_crc, use_pad, use_crc;
    logic             is_head, pass_beat, trunc, fire_out;
    logic [31:0]      fcs_word;

    // Mode requests as seen now; the pad request outranks the FCS-only request
    always_comb begin
        live_pad = cfg_pad_crc_en | pkt_pad_crc_en;
        live_crc = live_pad | cfg_crc_en;
        is_head  = (state_q == ST_IDLE);
        use_pad  = is_head ? live_pad : mode_pad_q;
        use_crc  = is_head ? live_crc : mode_crc_q;
    end

    // Position of the current data byte and the length-limit decision
    always_comb begin
        pass_beat = (is_head && in_sof) || (state_q == ST_BODY);
        byte_num  = is_head ? LEN_W'(1) : cnt_q + LEN_W'(1);
        trunc     = pass_beat && !cfg_huge_en && (byte_num == cfg_max_len) && !in_eof;
        fcs_word  = ~crc_q;
    end

    // Output stream and input back-pressure for each state
    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_sof   = 1'b0;
        out_eof   = 1'b0;
        out_err   = 1'b0;
        in_ready  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_BODY: begin
                if (pass_beat) begin
                    out_valid = in_valid;
                    out_data  = in_data;
                    out_sof   = is_head;
                    out_eof   = (in_eof && !use_crc) || trunc;
                    out_err   = trunc;
                    in_ready  = out_ready;
                end else begin
                    in_ready  = 1'b1;
                end
            end
            ST_PAD: out_valid = 1'b1;
            ST_FCS: begin
                out_valid = 1'b1;
                out_data  = fcs_word[8*idx_q +: 8];
                out_eof   = (idx_q == IDX_END);
            end
            ST_DROP: in_ready = 1'b1;
            default: in_ready = 1'b0;
        endcase
        fire_out  = out_valid && out_ready;
        crc_start = is_head;
        crc_step  = fire_out && (pass_beat || state_q == ST_PAD);
    end

    // Frame sequencing: data, then optional pad, then optional FCS
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_BODY: begin
                if (fire_out) begin
                    if (trunc)        state_d = ST_DROP;
                    else if (!in_eof) state_d = ST_BODY;
                    else if (!use_crc) state_d = ST_IDLE;
                    else if (use_pad && byte_num < MIN_LEN) state_d = ST_PAD;
                    else              state_d = ST_FCS;
                end
            end
            ST_PAD:  if (fire_out && cnt_q + LEN_W'(1) == MIN_LEN) state_d = ST_FCS;
            ST_FCS:  if (fire_out && idx_q == IDX_END) state_d = ST_IDLE;
            ST_DROP: if (in_valid && in_eof) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State, byte counter, FCS byte index and latched mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            idx_q      <= '0;
            mode_pad_q <= 1'b0;
            mode_crc_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (fire_out && pass_beat)         cnt_q <= byte_num;
            else if (fire_out && state_q == ST_PAD) cnt_q <= cnt_q + LEN_W'(1);
            if (state_q != ST_FCS)             idx_q <= '0;
            else if (fire_out)                 idx_q <= idx_q + IDX_W'(1);
            if (fire_out && is_head) begin
                mode_pad_q <= live_pad;
                mode_crc_q <= live_crc;
            end
        end
    end

    AST_PAD_BELOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAD) |-> (cnt_q < MIN_LEN) && mode_pad_q); // R3
    AST_FCS_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FCS) |-> mode_crc_q); // R2
    AST_FCS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FCS && !out_ready) |=> (state_q == ST_FCS) && $stable(idx_q)); // R9
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BODY && !cfg_huge_en) |-> (cnt_q < cfg_max_len)); // R7
    AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DROP) |-> !out_valid && in_ready); // R7
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(mode_pad_q) && $stable(mode_crc_q)); // R5

endmodule

// File: rtl/eth_tx_fcs_pad.sv
// Top level of the transmit pad/FCS inserter. It joins the frame sequencer
// and the CRC accumulator. The data path is combinational from input to
// output. Only the sequencer state and the CRC remainder are registered.
module eth_tx_fcs_pad #(
    parameter int LEN_W    = 16,
    parameter int MIN_DATA = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_pad_crc_en,
    input  logic             cfg_crc_en,
    input  logic             cfg_huge_en,
    input  logic [LEN_W-1:0] cfg_max_len,
    input  logic             pkt_pad_crc_en,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic             out_err
);

    logic        crc_start, crc_step;
    logic [31:0] crc_q;

    tx_frame_ctl #(.LEN_W(LEN_W), .MIN_DATA(MIN_DATA), .FCS_LEN(4)) u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_pad_crc_en (cfg_pad_crc_en),
        .cfg_crc_en     (cfg_crc_en),
        .cfg_huge_en    (cfg_huge_en),
        .cfg_max_len    (cfg_max_len),
        .pkt_pad_crc_en (pkt_pad_crc_en),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_data        (in_data),
        .in_sof         (in_sof),
        .in_eof         (in_eof),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_data       (out_data),
        .out_sof        (out_sof),
        .out_eof        (out_eof),
        .out_err        (out_err),
        .crc_start      (crc_start),
        .crc_step       (crc_step),
        .crc_q          (crc_q)
    );

    tx_crc32 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (crc_start),
        .step  (crc_step),
        .data  (out_data),
        .crc_q (crc_q)
    );

endmodule

// File: tb/sim_eth_tx_fcs_pad.sv
`timescale 1ns/1ps
module sim_eth_tx_fcs_pad;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cfg_pad_crc_en = 0, cfg_crc_en = 0, cfg_huge_en = 0, pkt_pad_crc_en = 0;
    logic [15:0] cfg_max_len = 16'd1518;
    logic        in_valid = 0, in_sof = 0, in_eof = 0, out_ready = 1;
    logic [7:0]  in_data = 0;
    logic        in_ready, out_valid, out_sof, out_eof, out_err;
    logic [7:0]  out_data;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    eth_tx_fcs_pad u0 (.*);

    // Vector table: length, pad, crc-only, per-frame pad, per-frame on start only, huge, max, back-pressure
    localparam int NV = 16;
    localparam int V_LEN [NV] = '{10, 1, 10, 70, 10, 59, 60, 61, 10, 10, 12, 12, 100, 100, 80, 100};
    localparam int V_PAD [NV] = '{ 0, 0,  0,  0,  1,  1,  1,  1,  1,  0,  0,  0,   0,   1,  0,   0};
    localparam int V_CRC [NV] = '{ 0, 0,  1,  1,  0,  0,  0,  0,  1,  1,  0,  0,   0,   0,  0,   1};
    localparam int V_PKT [NV] = '{ 0, 0,  0,  0,  0,  0,  0,  0,  0,  1,  1,  0,   0,   0,  0,   0};
    localparam int V_P1  [NV] = '{ 0, 0,  0,  0,  0,  0,  0,  0,  0,  0,  1,  0,   0,   0,  0,   0};
    localparam int V_HUGE[NV] = '{ 0, 0,  0,  0,  0,  0,  0,  0,  0,  0,  0,  0,   0,   0,  0,   1};
    localparam int V_MAX [NV] = '{1518,1518,1518,1518,1518,1518,1518,1518,1518,1518,1518,1518,80,80,80,80};
    localparam int V_BP  [NV] = '{ 0, 0,  0,  1,  0,  0,  0,  1,  0,  0,  0,  0,   0,   1,  0,   1};

    function automatic string vreq(int v);
        case (v)
            0, 1:          return "R1";
            2, 3:          return "R2";
            4, 5, 6, 7:    return "R3";
            8, 9:          return "R4";
            10, 11:        return "R5";
            12, 13, 14:    return "R7";
            15:            return "R8";
            default:       return "R10";
        endcase
    endfunction

    // Reference CRC in the non-reflected form with explicit bit reversal (R6)
    function automatic logic [31:0] ref_crc(input logic [7:0] b [256], input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        logic [31:0] r;
        for (int k = 0; k < n; k++) begin
            c = c ^ ({<<{b[k]}} << 24);
            for (int j = 0; j < 8; j++) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
        end
        r = {<<{c}};
        return ~r;
    endfunction

    logic [7:0] ob [256];
    logic       osof [256], oeof [256], oerr [256];
    logic [7:0] eb [256];

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input int len, pad, crc, pkt, p1, huge, mx, bp, seed, input string req);
        int in_idx = 0, got = 0, cyc = 0, elen, hold_bad = 0, mism = 0, mark_bad = 0;
        bit done_out = 0, prev_stall = 0, pend = 0, cut;
        logic [7:0] prev_data = 0;
        logic [31:0] f;
        @(negedge clk);
        cfg_pad_crc_en = pad[0]; cfg_crc_en = crc[0]; cfg_huge_en = huge[0];
        cfg_max_len = 16'(mx);
        while (!(in_idx == len && done_out) && cyc < 4000) begin
            @(negedge clk);
            in_valid = (in_idx < len) && (pend || !bp[0] || (cyc % 4 != 1));
            in_data  = 8'((in_idx * 7 + seed * 13 + 1) & 255);
            in_sof   = (in_idx == 0);
            in_eof   = (in_idx == len - 1);
            pkt_pad_crc_en = p1[0] ? (pkt[0] && in_idx == 0) : pkt[0];
            out_ready = bp[0] ? (cyc % 3 != 2) : 1'b1;
            #1;
            if (prev_stall && (!out_valid || out_data != prev_data)) hold_bad++;
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready && got < 256) begin
                ob[got] = out_data; osof[got] = out_sof; oeof[got] = out_eof; oerr[got] = out_err;
                got++;
                if (out_eof) done_out = 1;
            end
            pend = in_valid && !in_ready;
            if (in_valid && in_ready) in_idx++;
            cyc++;
        end
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0; out_ready = 1; pkt_pad_crc_en = 0;
        // Expected frame from the requirements
        cut = !huge[0] && len > mx;
        elen = cut ? mx : len;
        for (int k = 0; k < elen; k++) eb[k] = 8'((k * 7 + seed * 13 + 1) & 255);
        if (!cut && (pad[0] || pkt[0])) while (elen < 60) begin eb[elen] = 8'h00; elen++; end
        if (!cut && (pad[0] || pkt[0] || crc[0])) begin
            f = ref_crc(eb, elen);
            for (int k = 0; k < 4; k++) begin eb[elen] = f[8*k +: 8]; elen++; end
        end
        check(got == elen, req, "frame length", got, elen);
        for (int k = 0; k < got && k < elen; k++) if (ob[k] != eb[k]) mism++;
        check(mism == 0, req, "content incl. FCS (R6) mismatching bytes", mism, 0);
        for (int k = 0; k < got; k++) if (osof[k] != (k == 0) || oeof[k] != (k == got - 1)) mark_bad++;
        check(mark_bad == 0, req, "start/end marks misplaced", mark_bad, 0);
        check(got > 0 && oerr[got-1] == cut, req, "error mark on last byte",
              (got > 0) ? int'(oerr[got-1]) : -1, int'(cut));
        if (bp[0]) check(hold_bad == 0, "R9", "stalled byte not held", hold_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1..watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 0, "R10", "out_valid after reset", out_valid, 0);
        @(negedge clk) rst_n = 1;
        // R9: while passing data, in_ready follows out_ready
        @(negedge clk);
        in_valid = 1; in_sof = 1; in_eof = 0; in_data = 8'h55; out_ready = 0;
        #1;
        check(in_ready == 0 && out_valid == 1, "R9", "in_ready follows low out_ready", in_ready, 0);
        in_valid = 0; in_sof = 0; out_ready = 1;
        // R11: a stray byte with no start mark between frames is absorbed
        @(negedge clk);
        in_valid = 1; in_sof = 0; in_data = 8'hA5;
        #1;
        check(in_ready == 1 && out_valid == 0, "R11", "stray byte absorbed", {in_ready, out_valid}, 2);
        @(negedge clk) in_valid = 0;
        // Table-driven frames
        for (int v = 0; v < NV; v++)
            run_frame(V_LEN[v], V_PAD[v], V_CRC[v], V_PKT[v], V_P1[v], V_HUGE[v], V_MAX[v], V_BP[v], v, vreq(v));
        // R10: reset in the middle of a padded frame, then a plain frame
        @(negedge clk);
        cfg_pad_crc_en = 1; in_valid = 1; in_sof = 1; in_data = 8'h11;
        @(negedge clk); in_sof = 0;
        @(negedge clk); rst_n = 0; in_valid = 0;
        repeat (2) @(negedge clk);
        #1;
        check(out_valid == 0, "R10", "out_valid during reset mid-frame", out_valid, 0);
        rst_n = 1;
        run_frame(5, 0, 0, 0, 0, 0, 1518, 0, 20, "R10");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule